// File: doc/BRIEF.md
# CAN Bus Status Register

This block is the status word that a CAN protocol controller exposes to its host CPU. It keeps a 3-bit code for the most recent kind of bus error. It holds two sticky flags that record a successful transmission and a successful reception. It also shows, live, whether the node is error-active or error-passive.

The protocol engine drives the block with single-cycle strobes:

- an error strobe, which carries the error kind;
- a transmit-success strobe;
- a receive-success strobe;
- a tick that marks each run of eleven recessive bits seen during bus-off recovery.

A level input carries the error-passive state.

The CPU reads the word combinationally. It writes the word with a one-cycle write enable. When the CPU wants to know whether hardware has posted a fresh event, it writes the spare code 7 into the error-code field. Any later change away from 7 means a new event arrived.

Top module: `canbus_status`

## Requirements
- R1: After reset, every bit of `rd_data` reads 0, except bit 5, which follows `err_passive`.
- R2: An `err_stb` pulse with `err_kind` from 1 to 6 loads that value into bits 2:0 on the next clock. The codes are 1 stuff, 2 form, 3 acknowledge, 4 bit1, 5 bit0 and 6 CRC.
- R3: A `tx_ok` or `rx_ok` pulse clears bits 2:0 to 0 when no error strobe and no recovery tick occur in the same cycle.
- R4: An error strobe with a valid kind in the same cycle as a success pulse records the error code rather than clearing the field.
- R5: A `recov_tick` pulse loads code 5 into bits 2:0. If a valid error strobe arrives in the same cycle, the error kind wins.
- R6: A CPU write stores `wr_data[2:0]` in bits 2:0, including the sentinel 7. Hardware never produces 7. An error strobe whose kind is 0 or 7 is treated as no event.
- R7: Bit 3 (transmit OK) is set by `tx_ok`. Only a CPU write changes it otherwise, and the write stores `wr_data[3]` directly, so writing 1 is allowed.
- R8: Bit 4 (receive OK) is set by `rx_ok`. Only a CPU write changes it otherwise, and the write stores `wr_data[4]` directly.
- R9: When a hardware event and a CPU write touch the same field in one cycle, the hardware result is kept for that field.
- R10: Bit 5 always equals `err_passive`, and writes have no effect on it.
- R11: Bits 31:6 always read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 32 | CPU write data |
| rd_data | output | 32 | Status word read by the CPU |
| err_stb | input | 1 | Bus error event pulse |
| err_kind | input | 3 | Error kind that goes with `err_stb` |
| tx_ok | input | 1 | Frame sent without error and acknowledged |
| rx_ok | input | 1 | Frame received without error |
| recov_tick | input | 1 | Eleven recessive bits seen during bus-off recovery |
| err_passive | input | 1 | Node is error-passive |

## Verification
The hardest cases to reach are the collisions: a CPU write landing in the same cycle as one or more hardware strobes, and several strobes landing together. Each of these is decided by priority and not by a single cause.

The bench first forces the register into a chosen preset through the write port. It then applies, for one cycle, every combination of error strobe, error kind, both success strobes, the recovery tick and a concurrent write. Every resulting field is compared with a value derived from the priority rules.

The presets include the sentinel 7 and both flags set, so that clearing, holding and overwriting are each seen from a non-zero start.

// File: rtl/canbus_status.sv
module canbus_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        err_stb,
  input  logic [2:0]  err_kind,
  input  logic        tx_ok,
  input  logic        rx_ok,
  input  logic        recov_tick,
  input  logic        err_passive
);

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam logic [2:0] CODE_BIT0 = 3'd5;

  logic [2:0] code_q;
  logic       txf_q, rxf_q;

  wire unused_hi = ^wr_data[31:5];

  wire err_hit = err_stb && (err_kind != 3'd0) && (err_kind != 3'd7);
  wire ok_hit  = tx_ok || rx_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CODE_NONE;
    end else if (err_hit) begin
      code_q <= err_kind;
    end else if (recov_tick) begin
      code_q <= CODE_BIT0;
    end else if (ok_hit) begin
      code_q <= CODE_NONE;
    end else if (wr_en) begin
      code_q <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txf_q <= 1'b0;
      rxf_q <= 1'b0;
    end else begin
      if (tx_ok)      txf_q <= 1'b1;
      else if (wr_en) txf_q <= wr_data[3];
      if (rx_ok)      rxf_q <= 1'b1;
      else if (wr_en) rxf_q <= wr_data[4];
    end
  end

  assign rd_data = {26'd0, err_passive, rxf_q, txf_q, code_q};

  // R6
  no_hw_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[2:0] != 3'd7) |=> rd_data[2:0] != 3'd7);

  // R2
  err_code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stb && err_kind inside {[3'd1:3'd6]}) |=> rd_data[2:0] == $past(err_kind));

  // R5
  recov_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_tick && !(err_stb && err_kind inside {[3'd1:3'd6]})) |=> rd_data[2:0] == 3'd5);

  // R3
  ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_ok || rx_ok) && !err_stb && !recov_tick) |=> rd_data[2:0] == 3'd0);

  // R7
  tx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[3]) |=> rd_data[3]);

  // R8
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |=> rd_data[4]);

endmodule

// File: tb/canbus_status_tb.sv
module canbus_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err_stb = 1'b0;
  logic [2:0]  err_kind = '0;
  logic        tx_ok = 1'b0, rx_ok = 1'b0, recov_tick = 1'b0, err_passive = 1'b0;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  canbus_status u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .err_stb(err_stb), .err_kind(err_kind), .tx_ok(tx_ok),
    .rx_ok(rx_ok), .recov_tick(recov_tick), .err_passive(err_passive));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [31:0] wd, input logic es,
                       input logic [2:0] ek, input logic t, input logic r, input logic rc);
    @(negedge clk);
    wr_en = we; wr_data = wd; err_stb = es; err_kind = ek;
    tx_ok = t; rx_ok = r; recov_tick = rc;
    @(posedge clk); #1;
    wr_en = 0; wr_data = '0; err_stb = 0; err_kind = '0; tx_ok = 0; rx_ok = 0; recov_tick = 0;
    @(negedge clk);
  endtask

  function automatic logic [4:0] model(input logic [4:0] s, input logic we, input logic [31:0] wd,
      input logic es, input logic [2:0] ek, input logic t, input logic r, input logic rc);
    logic [2:0] c; logic tf, rf; logic ev;
    ev = es && ek >= 3'd1 && ek <= 3'd6;
    c = s[2:0]; tf = s[3]; rf = s[4];
    if (we) begin c = wd[2:0]; tf = wd[3]; rf = wd[4]; end
    if (t || r) c = 3'd0;
    if (rc) c = 3'd5;
    if (ev) c = ek;
    if (t) tf = 1'b1;
    if (r) rf = 1'b1;
    return {rf, tf, c};
  endfunction

  initial begin
    logic [4:0] presets [5];
    presets = '{5'h00, 5'h1F, 5'h07, 5'h0A, 5'h13};
    repeat (3) @(negedge clk);
    check("R1", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 32'h0);
    err_passive = 1'b1; #1;
    check("R10", rd_data, 32'h20);
    cycle(1, 32'hFFFF_FFC0, 0, 0, 0, 0, 0);
    check("R11", rd_data, 32'h20);
    cycle(1, 32'h0000_0020, 0, 0, 0, 0, 0);
    err_passive = 1'b0; #1;
    check("R10", rd_data, 32'h0);
    cycle(0, 0, 0, 0, 0, 1, 0);
    check("R8", rd_data[4:0], 5'h10);
    cycle(0, 0, 0, 0, 0, 0, 0);
    check("R8", rd_data[4:0], 5'h10);
    cycle(1, 32'h0, 0, 0, 0, 0, 0);
    check("R8", rd_data[4:0], 5'h00);
    cycle(1, 32'h7, 0, 0, 0, 0, 0);
    cycle(0, 0, 1, 3'd7, 0, 0, 0);
    check("R6", rd_data[4:0], 5'h07);

    for (int p = 0; p < 5; p++) begin
      for (int v = 0; v < 128; v++) begin
        logic es, t, r, rc, we; logic [2:0] ek; logic [31:0] wd; logic [4:0] exp5;
        string tag;
        es = v[0]; ek = v[3:1]; t = v[4]; r = v[5]; rc = v[6];
        for (int w = 0; w < 2; w++) begin
          we = w[0];
          wd = {26'h3FF_FFFF, 1'b1, presets[p] ^ 5'h1F};
          err_passive = p[0];
          cycle(1, {27'd0, presets[p]}, 0, 0, 0, 0, 0);
          check(presets[p][3] ? "R7" : "R6", rd_data, {26'd0, p[0], presets[p]});
          cycle(we, wd, es, ek, t, r, rc);
          exp5 = model(presets[p], we, wd, es, ek, t, r, rc);
          if (we && (es || t || r || rc)) tag = "R9";
          else if (es && ek >= 1 && ek <= 6) tag = (t || r) ? "R4" : "R2";
          else if (rc) tag = "R5";
          else if (t || r) tag = "R3";
          else if (we) tag = "R11";
          else tag = "R7";
          check(tag, rd_data, {26'd0, p[0], exp5});
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule